// File: doc/BRIEF.md
# DMA Session Handshake and Transfer Context Generator

This block is the front end of a multi-function DMA engine. A CPU programs six command words through a small register port. The words hold the operation mode, the source base and row pitch, the destination base and row pitch, and the block dimensions. A rising edge on the session request input opens a session. The block raises a bus request, waits for the hold grant, and then returns a session acknowledge to the requester.

In the same clock edge that raises the bus request, the mode field is decoded and a complete transfer context is latched into a register bank. That context holds the operation kind, the address steps for the write walk, and the dimensions. The transfer engine works from this bank only. The command words are therefore free for the next session as soon as the acknowledge appears. Context generation and bus arbitration overlap, so configuring costs no cycle beyond the grant wait.

The block starts the engine together with the acknowledge. It releases the bus when the engine reports completion. A mode that is not one-hot, or that has reserved bits set, is rejected and no session opens.

Top module: `dma_ctx_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all command words, the context bank, the read data and the outputs hreq, dack and eng_start.
- R2: A session opens only on a 0-to-1 change of dreq seen while idle. Holding dreq high opens no further session.
- R3: hreq rises on the clock edge that sees the dreq rise. dack rises on the first edge that samples hlda high while hreq is up, and not before.
- R4: Mode bits [3:0] of word 0 decode one-hot: 0001 gives copy (ctx_func 0), 0010 gives fuse (1), 0100 gives transpose (2), 1000 gives sort (3). Transpose sets the inner write step to the destination pitch and the outer step to 1. The other modes use an inner step of 1 and the destination pitch as the outer step. Sort forces rows to 1.
- R5: A mode whose bits [3:0] are not one-hot, or whose bits above 3 are not zero, is ignored. hreq stays low and the context bank keeps its previous contents.
- R6: The context bank loads on the same edge that raises hreq and holds its value for as long as hreq stays high.
- R7: Command words rewritten during a session change their readback value but leave the context bank unchanged.
- R8: eng_start rises together with dack and stays high until eng_done is sampled high. On that edge hreq, dack and eng_start all fall.
- R9: Word map: 0 mode, 1 source base, 2 source pitch, 3 destination base, 4 destination pitch, 5 dimensions (rows in bits [15:0], columns in bits [31:16]). cfg_rdata shows the word selected by cfg_addr one cycle later. Addresses 6 and 7 read as zero and ignore writes.
- R10: A dreq rise that arrives while a session is pending or running is dropped and is not queued for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Command word write enable |
| cfg_addr | input | 3 | Command word index |
| cfg_wdata | input | DW | Write data |
| cfg_rdata | output | DW | Registered readback of the selected word |
| dreq | input | 1 | Session request; its rising edge opens a session |
| hreq | output | 1 | Bus request |
| hlda | input | 1 | Bus hold grant |
| dack | output | 1 | Session acknowledge |
| eng_start | output | 1 | Start level to the transfer engine |
| eng_done | input | 1 | Transfer engine completion |
| ctx_mode | output | 4 | Latched one-hot mode |
| ctx_func | output | 2 | Latched operation kind |
| ctx_src_addr | output | DW | Latched source base |
| ctx_src_stride | output | DW | Latched source pitch |
| ctx_dst_addr | output | DW | Latched destination base |
| ctx_inner_step | output | DW | Write address step along a row |
| ctx_outer_step | output | DW | Write address step between rows |
| ctx_rows | output | DW/2 | Latched row count |
| ctx_cols | output | DW/2 | Latched column count |

## Verification
The hardest situation to reach is a second dreq rise that lands while the bus grant is still pending. The bench reaches it by dropping and raising dreq on consecutive cycles before driving hlda. It then confirms that no new bus request follows the completion of the session. A rewrite of the command words after the acknowledge is also difficult to observe. The bench performs the rewrite inside the running session. It then compares the context outputs with their pre-write values and compares the readback with the new word. Illegal modes follow a legal session in the vector table, so a context that failed to hold would show a visible change.

// File: rtl/dma_ctx_pkg.sv
package dma_ctx_pkg;
  localparam int unsigned NREG   = 6;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned MODE_W = 4;

  localparam int unsigned W_MODE    = 0;
  localparam int unsigned W_SRC     = 1;
  localparam int unsigned W_SSTRIDE = 2;
  localparam int unsigned W_DST     = 3;
  localparam int unsigned W_DSTRIDE = 4;
  localparam int unsigned W_DIMS    = 5;

  typedef enum logic [1:0] {
    FN_COPY  = 2'd0,
    FN_FUSE  = 2'd1,
    FN_XPOSE = 2'd2,
    FN_SORT  = 2'd3
  } fn_e;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_BUSREQ = 2'd1,
    HS_RUN    = 2'd2
  } hs_e;
endpackage

// File: rtl/cmd_regs.sv
module cmd_regs #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NR   = 6,
  parameter int unsigned AW   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [NR*DW-1:0] words,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < NR; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[g*DW +: DW] <= '0;
      else if (we && (int'(addr) == g))
        words[g*DW +: DW] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (int'(addr) < NR)
      rdata <= words[int'(addr)*DW +: DW];
    else
      rdata <= '0;
  end
endmodule

// File: rtl/req_edge.sv
module req_edge (
  input  logic clk,
  input  logic rst,
  input  logic req_in,
  output logic rise
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_in;
  end

  assign rise = req_in & ~req_q;
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
  import dma_ctx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic mode_ok,
  input  logic hlda,
  input  logic eng_done,
  output logic load,
  output logic hreq,
  output logic dack,
  output logic eng_start
);
  hs_e state;

  assign load = (state == HS_IDLE) && rise && mode_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= HS_IDLE;
      hreq      <= 1'b0;
      dack      <= 1'b0;
      eng_start <= 1'b0;
    end else begin
      unique case (state)
        HS_IDLE: begin
          if (load) begin
            state <= HS_BUSREQ;
            hreq  <= 1'b1;
          end
        end
        HS_BUSREQ: begin
          if (hlda) begin
            state     <= HS_RUN;
            dack      <= 1'b1;
            eng_start <= 1'b1;
          end
        end
        HS_RUN: begin
          if (eng_done) begin
            state     <= HS_IDLE;
            hreq      <= 1'b0;
            dack      <= 1'b0;
            eng_start <= 1'b0;
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctx_gen.sv
module ctx_gen
  import dma_ctx_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned HW = DW / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DW-1:0]     mode_word,
  input  logic [DW-1:0]     src,
  input  logic [DW-1:0]     sstride,
  input  logic [DW-1:0]     dst,
  input  logic [DW-1:0]     dstride,
  input  logic [DW-1:0]     dims,
  output logic              mode_ok,
  output logic [MODE_W-1:0] c_mode,
  output logic [1:0]        c_func,
  output logic [DW-1:0]     c_src,
  output logic [DW-1:0]     c_sstride,
  output logic [DW-1:0]     c_dst,
  output logic [DW-1:0]     c_inner,
  output logic [DW-1:0]     c_outer,
  output logic [HW-1:0]     c_rows,
  output logic [HW-1:0]     c_cols
);
  logic [MODE_W-1:0] mode;
  fn_e               dec;

  assign mode    = mode_word[MODE_W-1:0];
  assign mode_ok = $onehot(mode) && (mode_word[DW-1:MODE_W] == '0);

  always_comb begin
    unique case (mode)
      4'b0010: dec = FN_FUSE;
      4'b0100: dec = FN_XPOSE;
      4'b1000: dec = FN_SORT;
      default: dec = FN_COPY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_mode    <= '0;
      c_func    <= '0;
      c_src     <= '0;
      c_sstride <= '0;
      c_dst     <= '0;
      c_inner   <= '0;
      c_outer   <= '0;
      c_rows    <= '0;
      c_cols    <= '0;
    end else if (load) begin
      c_mode    <= mode;
      c_func    <= dec;
      c_src     <= src;
      c_sstride <= sstride;
      c_dst     <= dst;
      c_cols    <= dims[DW-1:HW];
      if (dec == FN_XPOSE) begin
        c_inner <= dstride;
        c_outer <= DW'(1);
      end else begin
        c_inner <= DW'(1);
        c_outer <= dstride;
      end
      if (dec == FN_SORT) c_rows <= HW'(1);
      else                c_rows <= dims[HW-1:0];
    end
  end
endmodule

// File: rtl/dma_ctx_ctrl.sv
module dma_ctx_ctrl
  import dma_ctx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [REG_AW-1:0]   cfg_addr,
  input  logic [DW-1:0]       cfg_wdata,
  output logic [DW-1:0]       cfg_rdata,
  input  logic                dreq,
  output logic                hreq,
  input  logic                hlda,
  output logic                dack,
  output logic                eng_start,
  input  logic                eng_done,
  output logic [MODE_W-1:0]   ctx_mode,
  output logic [1:0]          ctx_func,
  output logic [DW-1:0]       ctx_src_addr,
  output logic [DW-1:0]       ctx_src_stride,
  output logic [DW-1:0]       ctx_dst_addr,
  output logic [DW-1:0]       ctx_inner_step,
  output logic [DW-1:0]       ctx_outer_step,
  output logic [DW/2-1:0]     ctx_rows,
  output logic [DW/2-1:0]     ctx_cols
);
  logic [NREG*DW-1:0] words;
  logic [DW-1:0]      mode_word;
  logic               rise;
  logic               mode_ok;
  logic               load;

  assign mode_word = words[W_MODE*DW +: DW];

  cmd_regs #(.DW(DW), .NR(NREG), .AW(REG_AW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .words (words),
    .rdata (cfg_rdata)
  );

  req_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .req_in (dreq),
    .rise   (rise)
  );

  hs_fsm u_hs (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise),
    .mode_ok   (mode_ok),
    .hlda      (hlda),
    .eng_done  (eng_done),
    .load      (load),
    .hreq      (hreq),
    .dack      (dack),
    .eng_start (eng_start)
  );

  ctx_gen #(.DW(DW)) u_ctx (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .mode_word (mode_word),
    .src       (words[W_SRC*DW +: DW]),
    .sstride   (words[W_SSTRIDE*DW +: DW]),
    .dst       (words[W_DST*DW +: DW]),
    .dstride   (words[W_DSTRIDE*DW +: DW]),
    .dims      (words[W_DIMS*DW +: DW]),
    .mode_ok   (mode_ok),
    .c_mode    (ctx_mode),
    .c_func    (ctx_func),
    .c_src     (ctx_src_addr),
    .c_sstride (ctx_src_stride),
    .c_dst     (ctx_dst_addr),
    .c_inner   (ctx_inner_step),
    .c_outer   (ctx_outer_step),
    .c_rows    (ctx_rows),
    .c_cols    (ctx_cols)
  );
endmodule

// File: rtl/dma_ctx_ctrl_chk.sv
module dma_ctx_ctrl_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          dreq,
  input logic          hlda,
  input logic          eng_done,
  input logic          hreq,
  input logic          dack,
  input logic          eng_start,
  input logic [3:0]    ctx_mode,
  input logic [DW-1:0] ctx_src_addr,
  input logic [DW-1:0] mode_word
);
  p_hreq_on_edge_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hreq) |-> ($past(dreq) && !$past(hreq)));

  p_dack_after_grant_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(dack) |-> ($past(hlda) && $past(hreq)));

  p_start_with_dack_r8: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> (dack && hreq));

  p_release_on_done_r8: assert property (@(posedge clk) disable iff (rst)
    (eng_start && eng_done) |=> (!hreq && !dack && !eng_start));

  p_ctx_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctx_mode));

  p_ctx_held_r6: assert property (@(posedge clk) disable iff (rst)
    (hreq && $past(hreq)) |-> ($stable(ctx_mode) && $stable(ctx_src_addr)));

  p_illegal_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (!hreq && dreq && !$past(dreq) &&
     !($onehot(mode_word[3:0]) && (mode_word[DW-1:4] == '0))) |=> !hreq);
endmodule

bind dma_ctx_ctrl dma_ctx_ctrl_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dreq         (dreq),
  .hlda         (hlda),
  .eng_done     (eng_done),
  .hreq         (hreq),
  .dack         (dack),
  .eng_start    (eng_start),
  .ctx_mode     (ctx_mode),
  .ctx_src_addr (ctx_src_addr),
  .mode_word    (mode_word)
);

// File: tb/tb_dma_ctx_ctrl.sv
module tb_dma_ctx_ctrl;
  localparam int CLK_P = 10;
  localparam int DW    = 32;
  localparam int WD    = 20000;
  localparam int NV    = 8;

  localparam logic [31:0] V_MODE [NV] = '{32'h1, 32'h2, 32'h4, 32'h8,
                                          32'h0, 32'h6, 32'hF, 32'h12};
  localparam logic        V_OK   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1,
                                          1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [1:0]  V_FUNC [NV] = '{2'd0, 2'd1, 2'd2, 2'd3,
                                          2'd0, 2'd0, 2'd0, 2'd0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic dreq = 1'b0, hlda = 1'b0, eng_done = 1'b0;
  logic hreq, dack, eng_start;
  logic [3:0] ctx_mode;
  logic [1:0] ctx_func;
  logic [DW-1:0] ctx_src_addr, ctx_src_stride, ctx_dst_addr, ctx_inner_step, ctx_outer_step;
  logic [DW/2-1:0] ctx_rows, ctx_cols;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [3:0] e_mode;
  logic [1:0] e_func;
  logic [DW-1:0] e_src, e_sst, e_dst, e_in, e_out;
  logic [15:0] e_rows, e_cols;

  always #(CLK_P/2) clk = ~clk;

  dma_ctx_ctrl #(.DW(DW)) dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic chk_ctx(input string tag);
    chk({tag, " mode"}, ctx_mode, e_mode);
    chk({tag, " func"}, ctx_func, e_func);
    chk({tag, " src"},  ctx_src_addr, e_src);
    chk({tag, " sst"},  ctx_src_stride, e_sst);
    chk({tag, " dst"},  ctx_dst_addr, e_dst);
    chk({tag, " inner"}, ctx_inner_step, e_in);
    chk({tag, " outer"}, ctx_outer_step, e_out);
    chk({tag, " rows"}, ctx_rows, e_rows);
    chk({tag, " cols"}, ctx_cols, e_cols);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    e_mode = '0; e_func = '0; e_src = '0; e_sst = '0; e_dst = '0;
    e_in = '0; e_out = '0; e_rows = '0; e_cols = '0;
    repeat (3) cyc();
    // R1 reset state
    chk("R1 hreq", hreq, 0); chk("R1 dack", dack, 0);
    chk("R1 start", eng_start, 0); chk("R1 rdata", cfg_rdata, 0);
    chk_ctx("R1 ctx");
    rst = 1'b0;
    cyc();

    for (int i = 0; i < NV; i++) begin
      logic [DW-1:0] src, sst, dst, dstr;
      logic [15:0] rows, cols;
      src = 32'h1000_0000 + i * 16; sst = 32'h40 + i;
      dst = 32'h2000_0000 + i * 32; dstr = 32'h80 + i;
      rows = 16'(2 + i); cols = 16'(3 + i);
      wr(0, V_MODE[i]); wr(1, src); wr(2, sst); wr(3, dst); wr(4, dstr);
      wr(5, {cols, rows});
      cfg_addr = 3'd5; cyc();
      chk("R9 dims readback", cfg_rdata, {cols, rows});
      dreq = 1'b1; cyc();
      chk("R3/R5 hreq after edge", hreq, V_OK[i]);
      if (V_OK[i]) begin
        e_mode = V_MODE[i][3:0]; e_func = V_FUNC[i];
        e_src = src; e_sst = sst; e_dst = dst; e_cols = cols;
        e_in  = (V_FUNC[i] == 2'd2) ? dstr : 32'd1;
        e_out = (V_FUNC[i] == 2'd2) ? 32'd1 : dstr;
        e_rows = (V_FUNC[i] == 2'd3) ? 16'd1 : rows;
        chk_ctx("R4/R6 ctx");
        chk("R3 no dack before hlda", dack, 0);
        cyc();
        chk("R3 dack waits hlda", dack, 0);
        hlda = 1'b1; cyc(); hlda = 1'b0;
        chk("R3 dack", dack, 1); chk("R8 start", eng_start, 1);
        wr(1, 32'hDEAD_BEEF);
        cfg_addr = 3'd1; cyc();
        chk("R7 readback new", cfg_rdata, 32'hDEAD_BEEF);
        chk_ctx("R7 ctx held");
        chk("R8 start held", eng_start, 1);
        eng_done = 1'b1; cyc(); eng_done = 1'b0;
        chk("R8 hreq drop", hreq, 0); chk("R8 dack drop", dack, 0);
        chk("R8 start drop", eng_start, 0);
        cyc(); cyc();
        chk("R2 level no session", hreq, 0);
      end else begin
        cyc();
        chk("R5 still idle", hreq, 0);
        chk_ctx("R5 ctx kept");
      end
      dreq = 1'b0; cyc();
    end

    // R10 edge while pending is dropped
    wr(0, 32'h4); dreq = 1'b1; cyc();
    chk("R10 session open", hreq, 1);
    dreq = 1'b0; cyc(); dreq = 1'b1; cyc();
    hlda = 1'b1; cyc(); hlda = 1'b0;
    eng_done = 1'b1; cyc(); eng_done = 1'b0;
    chk("R10 released", hreq, 0);
    cyc(); cyc();
    chk("R10 not queued", hreq, 0);
    dreq = 1'b0; cyc();

    // R9 unmapped addresses
    wr(6, 32'h1234_5678);
    cfg_addr = 3'd6; cyc();
    chk("R9 addr6 zero", cfg_rdata, 0);
    cfg_addr = 3'd7; cyc();
    chk("R9 addr7 zero", cfg_rdata, 0);
    cfg_addr = 3'd0; cyc();
    chk("R9 mode readback", cfg_rdata, 32'h4);

    // R1 reset mid-session
    dreq = 1'b1; cyc();
    chk("R1 pre-reset hreq", hreq, 1);
    rst = 1'b1; cyc(); rst = 1'b0;
    chk("R1 mid reset hreq", hreq, 0);
    chk("R1 mid reset ctx", ctx_mode, 0);
    cfg_addr = 3'd0; cyc();
    chk("R1 mid reset word", cfg_rdata, 0);
    dreq = 1'b0; cyc();

    finished = 1;
    summary();
    $finish;
  end
endmodule